// File: doc/BRIEF.md
# Windowed Event Performance Counters

This block keeps a small bank of saturating event counters for measuring a stretch of program execution. Each channel picks one event source through its own selector: elapsed CPU cycles, retired instructions, taken branches, exceptions or cache misses. A channel can also be switched off. All channels share one measurement window. A mode input chooses what opens and closes that window: program start and break, or one of the two break-condition match events followed by the other.

Counting advances only on cycles where the CPU clock enable is high, so a core held in sleep adds nothing. A count that would go past its maximum stays at all ones and raises a sticky per-channel overflow flag. An initialize pulse clears every result and every flag, and closes the window. When a condition-driven mode is chosen while no channel watches an event, the setting is refused: an error output is raised and the window is held shut.

Top module: `evt_perf_counters`

## Requirements
- R1: There are NUM_CH (default 4) channels. Channel k is set by ch_sel bits [3k+2:3k] with these codes: 1 = cycles, 2 = instructions, 3 = branches, 4 = exceptions, 5 = cache misses. Codes 0, 6 and 7 disable the channel, and a disabled channel never changes.
- R2: Each count is an unsigned CNT_W-bit value (default 32). Channel k occupies cnt_o bits [CNT_W*k+CNT_W-1 : CNT_W*k].
- R3: On each counting cycle, code 1 adds 1. Codes 2, 4 and 5 add 1 when their event input is high. Code 3 adds 2 when evt_branch is high.
- R4: win_mode selects the window events. 0: run_start opens, brk_hit closes. 1: cond1_hit opens, cond2_hit closes. 2: cond2_hit opens, cond1_hit closes. 3: the window never opens. An event of the wrong role has no effect.
- R5: win_open goes high one cycle after a start event. The cycle carrying the start event is not counted. A cycle where the window is open and the stop event is present is not counted, and win_open falls after that cycle. Start events while the window is open are ignored.
- R6: While cpu_clk_en is low, no count changes.
- R7: An increment that would exceed 2^CNT_W-1 leaves the count at all ones and sets that channel's ovf_o bit. Reaching exactly all ones does not set the flag.
- R8: Once set, an ovf_o bit stays high until perf_init. A saturated count stays at all ones.
- R9: A perf_init pulse clears all counts and overflow bits and closes the window on the next edge. It takes priority over counting.
- R10: cfg_err is high when win_mode is 1 or 2 and no channel holds code 1 to 5. While cfg_err is high, the window is closed and cannot open.
- R11: After reset, all counts are zero, all overflow bits are clear and the window is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_clk_en | input | 1 | CPU clock enable; low during sleep |
| perf_init | input | 1 | Clear all results and close the window |
| win_mode | input | 2 | Window mode selector |
| ch_sel | input | 3*NUM_CH | Per-channel event selector codes |
| run_start | input | 1 | Program start pulse |
| brk_hit | input | 1 | Break taken pulse |
| cond1_hit | input | 1 | Break condition 1 matched |
| cond2_hit | input | 1 | Break condition 2 matched |
| evt_instr | input | 1 | Instruction retired this cycle |
| evt_branch | input | 1 | Branch taken this cycle |
| evt_except | input | 1 | Exception taken this cycle |
| evt_miss | input | 1 | Cache miss this cycle |
| cnt_o | output | CNT_W*NUM_CH | Packed channel counts |
| ovf_o | output | NUM_CH | Sticky overflow flags |
| win_open | output | 1 | Measurement window currently open |
| cfg_err | output | 1 | Condition mode refused: no event selected |

## Verification
The bench uses an 8-bit counter configuration so that saturation is reached quickly, and sweeps all four modes against several selector patterns under pseudo-random events.

It targets the following corner cases:
- Off-by-one errors at the window edges. A design that counts the start or stop cycle ends one count high.
- A branch step of 2 landing one short of the maximum. A design that wraps there shows a small count with no flag.
- A count that reaches all ones exactly. A design that flags this case raises overflow too early.
- A repeated start inside an open window. A design that restarts on it would stop counting or reopen the window.
- The refused condition mode. A design that does not refuse it opens a window with nothing to count.

// File: rtl/perf_pkg.sv
package perf_pkg;

  localparam int SEL_W = 3;

  localparam logic [SEL_W-1:0] SEL_CYCLE  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_INSTR  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_BRANCH = 3'd3;
  localparam logic [SEL_W-1:0] SEL_EXCEPT = 3'd4;
  localparam logic [SEL_W-1:0] SEL_MISS   = 3'd5;

  typedef enum logic [1:0] {
    WIN_RUN  = 2'd0,
    WIN_C1C2 = 2'd1,
    WIN_C2C1 = 2'd2,
    WIN_NONE = 2'd3
  } win_mode_e;

  typedef struct packed {
    logic instr;
    logic branch;
    logic except;
    logic miss;
  } evt_bus_t;

endpackage

// File: rtl/perf_event_mux.sv
module perf_event_mux
  import perf_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  evt_bus_t         evt,
  output logic [1:0]       inc,
  output logic             active
);

  always_comb begin
    inc    = 2'd0;
    active = 1'b1;
    case (sel)
      SEL_CYCLE:  inc = 2'd1;
      SEL_INSTR:  inc = {1'b0, evt.instr};
      SEL_BRANCH: inc = {evt.branch, 1'b0};
      SEL_EXCEPT: inc = {1'b0, evt.except};
      SEL_MISS:   inc = {1'b0, evt.miss};
      default: begin
        inc    = 2'd0;
        active = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/perf_window.sv
module perf_window
  import perf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       any_active,
  input  logic       init,
  input  logic       run_start,
  input  logic       brk_hit,
  input  logic       cond1_hit,
  input  logic       cond2_hit,
  output logic       win_q,
  output logic       stop_evt,
  output logic       err
);

  win_mode_e mode_e;
  logic      start_evt;
  logic      win_d;

  assign mode_e = win_mode_e'(mode);

  always_comb begin
    start_evt = 1'b0;
    stop_evt  = 1'b1;
    case (mode_e)
      WIN_RUN: begin
        start_evt = run_start;
        stop_evt  = brk_hit;
      end
      WIN_C1C2: begin
        start_evt = cond1_hit;
        stop_evt  = cond2_hit;
      end
      WIN_C2C1: begin
        start_evt = cond2_hit;
        stop_evt  = cond1_hit;
      end
      default: begin
        start_evt = 1'b0;
        stop_evt  = 1'b1;
      end
    endcase
  end

  assign err = ((mode_e == WIN_C1C2) || (mode_e == WIN_C2C1)) && !any_active;

  always_comb begin
    if (init || err)
      win_d = 1'b0;
    else if (win_q)
      win_d = !stop_evt;
    else
      win_d = start_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      win_q <= 1'b0;
    else
      win_q <= win_d;
  end

  p_err_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !win_q);

  p_start_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q && !stop_evt && !init && !err) |=> win_q);

  p_open_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_q && start_evt && !init && !err) |=> win_q);

  p_init_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> !win_q);

endmodule

// File: rtl/perf_sat_counter.sv
module perf_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [1:0]       inc,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_d;
  logic             ovf_d;

  assign sum = {1'b0, cnt_q} + {{(CNT_W-1){1'b0}}, inc};

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (clr) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (en) begin
      if (sum[CNT_W]) begin
        cnt_d = CNT_MAX;
        ovf_d = 1'b1;
      end else begin
        cnt_d = sum[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q == CNT_MAX));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr) |=> ovf_q);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(cnt_q));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0) && !ovf_q);

endmodule

// File: rtl/evt_perf_counters.sv
module evt_perf_counters
  import perf_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_clk_en,
  input  logic                    perf_init,
  input  logic [1:0]              win_mode,
  input  logic [NUM_CH*SEL_W-1:0] ch_sel,
  input  logic                    run_start,
  input  logic                    brk_hit,
  input  logic                    cond1_hit,
  input  logic                    cond2_hit,
  input  logic                    evt_instr,
  input  logic                    evt_branch,
  input  logic                    evt_except,
  input  logic                    evt_miss,
  output logic [NUM_CH*CNT_W-1:0] cnt_o,
  output logic [NUM_CH-1:0]       ovf_o,
  output logic                    win_open,
  output logic                    cfg_err
);

  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_ns;
  evt_bus_t              evt;
  logic [1:0]            inc_w [NUM_CH];
  logic [NUM_CH-1:0]     act_w;
  logic                  stop_w;
  logic                  cnt_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe_q <= '0;
    else
      rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_ns = rst_pipe_q[RST_STAGES-1];

  assign evt = '{instr: evt_instr, branch: evt_branch, except: evt_except, miss: evt_miss};

  perf_window u_win (
    .clk        (clk),
    .rst_n      (rst_ns),
    .mode       (win_mode),
    .any_active (|act_w),
    .init       (perf_init),
    .run_start  (run_start),
    .brk_hit    (brk_hit),
    .cond1_hit  (cond1_hit),
    .cond2_hit  (cond2_hit),
    .win_q      (win_open),
    .stop_evt   (stop_w),
    .err        (cfg_err)
  );

  assign cnt_en = win_open && !stop_w && cpu_clk_en;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    perf_event_mux u_mux (
      .sel    (ch_sel[ch*SEL_W +: SEL_W]),
      .evt    (evt),
      .inc    (inc_w[ch]),
      .active (act_w[ch])
    );

    perf_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_ns),
      .clr   (perf_init),
      .en    (cnt_en),
      .inc   (inc_w[ch]),
      .cnt_q (cnt_o[ch*CNT_W +: CNT_W]),
      .ovf_q (ovf_o[ch])
    );
  end

  p_sleep_gate_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    (!cpu_clk_en && !perf_init) |=> $stable(cnt_o));

  p_closed_hold_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    (!win_open && !perf_init) |=> $stable(cnt_o));

endmodule

// File: tb/sim_evt_perf_counters.sv
`timescale 1ns/1ps
module sim_evt_perf_counters;

  localparam int NCH  = 4;
  localparam int CW   = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk, rst_n, ce, ini;
  logic [1:0] mode_r;
  logic [NCH*3-1:0] sel_r;
  logic rs, bk, c1, c2, ins, br, ex, ms;
  logic [NCH*CW-1:0] cnt_w;
  logic [NCH-1:0] ovf_w;
  logic win_w, err_w;

  int n_chk, n_fail;
  bit done;
  int m_cnt [NCH];
  bit m_ovf [NCH];
  bit m_win;
  logic [15:0] lfsr;

  evt_perf_counters #(.NUM_CH(NCH), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_clk_en(ce), .perf_init(ini),
    .win_mode(mode_r), .ch_sel(sel_r), .run_start(rs), .brk_hit(bk),
    .cond1_hit(c1), .cond2_hit(c2), .evt_instr(ins), .evt_branch(br),
    .evt_except(ex), .evt_miss(ms), .cnt_o(cnt_w), .ovf_o(ovf_w),
    .win_open(win_w), .cfg_err(err_w)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int inc_of(input logic [2:0] code);
    case (code)
      3'd1: return 1;
      3'd2: return ins ? 1 : 0;
      3'd3: return br ? 2 : 0;
      3'd4: return ex ? 1 : 0;
      3'd5: return ms ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_err();
    bit any;
    any = 0;
    for (int k = 0; k < NCH; k++)
      if (sel_r[3*k +: 3] >= 3'd1 && sel_r[3*k +: 3] <= 3'd5) any = 1;
    return (mode_r == 2'd1 || mode_r == 2'd2) && !any;
  endfunction

  task automatic compare_all();
    chk("R5 window", int'(win_w), int'(m_win));
    chk("R10 cfg_err", int'(err_w), int'(exp_err()));
    for (int k = 0; k < NCH; k++) begin
      chk("R3 count", int'(cnt_w[CW*k +: CW]), m_cnt[k]);
      chk("R7 overflow", int'(ovf_w[k]), int'(m_ovf[k]));
    end
  endtask

  // Inputs are driven at the falling edge; the model advances with the
  // rising edge and the outputs are compared 1 ns after it.
  task automatic step(input bit i_rs, input bit i_bk, input bit i_c1, input bit i_c2,
                      input bit i_ins, input bit i_br, input bit i_ex, input bit i_ms,
                      input bit i_ce, input bit i_ini);
    bit st, sp, er, cen;
    int sum;
    @(negedge clk);
    rs = i_rs; bk = i_bk; c1 = i_c1; c2 = i_c2;
    ins = i_ins; br = i_br; ex = i_ex; ms = i_ms; ce = i_ce; ini = i_ini;
    case (mode_r)
      2'd0: begin st = rs; sp = bk; end
      2'd1: begin st = c1; sp = c2; end
      2'd2: begin st = c2; sp = c1; end
      default: begin st = 0; sp = 1; end
    endcase
    er  = exp_err();
    cen = m_win && !sp && ce;
    for (int k = 0; k < NCH; k++) begin
      if (ini) begin
        m_cnt[k] = 0;
        m_ovf[k] = 0;
      end else if (cen) begin
        sum = m_cnt[k] + inc_of(sel_r[3*k +: 3]);
        if (sum > CMAX) begin
          m_cnt[k] = CMAX;
          m_ovf[k] = 1;
        end else begin
          m_cnt[k] = sum;
        end
      end
    end
    if (ini || er) m_win = 0;
    else if (m_win) m_win = !sp;
    else m_win = st;
    @(posedge clk);
    #1;
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0,0,0,0,0,0,0,0,1,0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [NCH*3-1:0] pats [4];
    n_chk = 0; n_fail = 0; done = 0;
    pats[0] = {3'd4, 3'd3, 3'd2, 3'd1};
    pats[1] = {3'd1, 3'd0, 3'd3, 3'd5};
    pats[2] = {3'd6, 3'd7, 3'd3, 3'd0};
    pats[3] = '0;
    lfsr = 16'hACE1;
    rst_n = 0; ce = 1; ini = 0; mode_r = 0; sel_r = pats[0];
    rs = 0; bk = 0; c1 = 0; c2 = 0; ins = 0; br = 0; ex = 0; ms = 0;
    for (int k = 0; k < NCH; k++) begin m_cnt[k] = 0; m_ovf[k] = 0; end
    m_win = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    chk("R11 counts zero", int'(cnt_w), 0);
    chk("R11 ovf clear", int'(ovf_w), 0);
    chk("R11 window closed", int'(win_w), 0);
    // R2: packed width
    chk("R2 count width", $bits(cnt_w), NCH * CW);

    // Sweep: every mode against every selector pattern, pseudo-random events.
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        mode_r = 2'(m);
        sel_r  = pats[p];
        step(0,0,0,0,0,0,0,0,1,1);
        for (int i = 0; i < 300; i++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          step(lfsr[3:0] == 4'd0, lfsr[7:4] == 4'd0, lfsr[11:8] == 4'd1,
               lfsr[15:12] == 4'd2, lfsr[0], lfsr[5], lfsr[9] & lfsr[2],
               lfsr[13], lfsr[14:12] != 3'd0, 1'b0);
        end
      end
    end

    // Directed window edges, mode 0: ch0 counts cycles, ch1 counts branches.
    @(negedge clk);
    mode_r = 2'd0;
    sel_r = {3'd0, 3'd0, 3'd3, 3'd1};
    step(0,0,0,0,0,0,0,0,1,1);
    step(1,0,0,0,0,0,0,0,1,0);
    chk("R5 open after start", int'(win_w), 1);
    chk("R5 start cycle not counted", int'(cnt_w[CW-1:0]), 0);
    idle(5);
    chk("R3 cycle count", int'(cnt_w[CW-1:0]), 5);
    step(1,0,0,0,0,0,0,0,1,0);
    chk("R5 restart ignored", int'(cnt_w[CW-1:0]), 6);
    chk("R5 restart keeps window", int'(win_w), 1);
    for (int i = 0; i < 3; i++) step(0,0,0,0,0,1,0,0,0,0);
    chk("R6 sleep holds cycles", int'(cnt_w[CW-1:0]), 6);
    chk("R6 sleep holds branches", int'(cnt_w[2*CW-1:CW]), 0);
    step(0,0,0,0,0,1,0,0,1,0);
    chk("R3 branch adds two", int'(cnt_w[2*CW-1:CW]), 2);
    step(0,1,0,0,0,1,0,0,1,0);
    chk("R5 stop cycle not counted", int'(cnt_w[CW-1:0]), 7);
    chk("R5 closed after stop", int'(win_w), 0);
    step(0,0,0,0,0,1,0,0,1,0);
    chk("R5 closed holds", int'(cnt_w[2*CW-1:CW]), 2);

    // Saturation: branches step by two from 2 up to 254, then one more.
    step(1,0,0,0,0,0,0,0,1,0);
    while (m_cnt[1] < CMAX - 1) step(0,0,0,0,0,1,0,0,1,0);
    chk("R7 branch at 254", int'(cnt_w[2*CW-1:CW]), CMAX - 1);
    chk("R7 no flag yet", int'(ovf_w[1]), 0);
    step(0,0,0,0,0,1,0,0,1,0);
    chk("R7 saturated", int'(cnt_w[2*CW-1:CW]), CMAX);
    chk("R7 flag set", int'(ovf_w[1]), 1);
    while (m_cnt[0] < CMAX) step(0,0,0,0,0,0,0,0,1,0);
    chk("R7 exact max no flag", int'(ovf_w[0]), 0);
    step(0,0,0,0,0,0,0,0,1,0);
    chk("R7 cycles flag", int'(ovf_w[0]), 1);
    step(0,1,0,0,0,0,0,0,1,0);
    idle(4);
    chk("R8 sticky flags", int'(ovf_w[1:0]), 3);
    chk("R8 held max", int'(cnt_w[CW-1:0]), CMAX);
    step(0,0,0,0,0,0,0,0,1,1);
    chk("R9 init counts", int'(cnt_w), 0);
    chk("R9 init flags", int'(ovf_w), 0);

    // R4: condition ordering in mode 1.
    @(negedge clk);
    mode_r = 2'd1;
    step(0,0,0,1,0,0,0,0,1,0);
    chk("R4 cond2 does not open", int'(win_w), 0);
    step(0,0,1,0,0,0,0,0,1,0);
    chk("R4 cond1 opens", int'(win_w), 1);
    step(0,0,0,1,0,0,0,0,1,0);
    chk("R4 cond2 closes", int'(win_w), 0);
    // R1: disabled codes never count.
    @(negedge clk);
    mode_r = 2'd0;
    sel_r = {3'd7, 3'd6, 3'd0, 3'd1};
    step(0,0,0,0,0,0,0,0,1,1);
    step(1,0,0,0,0,0,0,0,1,0);
    for (int i = 0; i < 6; i++) step(0,0,0,0,1,1,1,1,1,0);
    chk("R1 disabled channels", int'(cnt_w[4*CW-1:CW]), 0);
    chk("R1 enabled channel", int'(cnt_w[CW-1:0]), 6);
    // R10: refused condition mode.
    @(negedge clk);
    sel_r = '0;
    mode_r = 2'd2;
    step(0,0,0,1,0,0,0,0,1,0);
    chk("R10 error raised", int'(err_w), 1);
    chk("R10 window held shut", int'(win_w), 0);
    @(negedge clk);
    mode_r = 2'd0;
    #1;
    chk("R10 run mode accepted", int'(err_w), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule